// File: doc/BRIEF.md
# Variable-Length Branch Trace Message Packer

This block builds one branch trace message at a time from its separate fields and hands out the packed bit vector together with its total bit count. It serves a debug trace path. Upstream logic offers the fields of a branch event through a valid/ready handshake. Downstream logic takes the finished message through a second valid/ready handshake and serializes it by its length.

The block knows two message kinds. The plain sync kind carries a 6-bit opcode, a 4-bit source tag, an instruction count and a full target address. The history kind also carries a branch history word. The opcode and the source tag have fixed widths. Each of the other fields is cut down to its significant bits, so a small value costs few bits. Fields are laid down from the least significant end: opcode, source, count, address and then history. Every field starts directly above the previous one. Bits above the used length read zero. The message becomes visible one cycle after it is accepted.

Top module: `trace_msg_packer`

## Requirements
- R1: Bits [5:0] of `out_data` hold the opcode. A plain sync message (`in_kind`=0) gives 6'b001011 when `in_indirect`=0 and 6'b001100 when `in_indirect`=1. A history message (`in_kind`=1) gives 6'b011101 whatever `in_indirect` is.
- R2: Bits [9:6] of `out_data` hold `in_src` unchanged.
- R3: The instruction count starts at bit 10. Its width is the index of its highest set bit plus one, and a zero value takes 1 bit.
- R4: The address starts at the bit directly above the instruction count. It is sized by the same rule.
- R5: A history message places the history word, sized by the same rule, directly above the address. A plain sync message leaves out the history word, and `in_hist` has no effect on its output.
- R6: `out_len` equals the sum of the field widths. It lies in 12..50 for the plain kind and in 13..82 for the history kind.
- R7: Every bit of `out_data` at position `out_len` or above is zero.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_len` hold their values.
- R9: `in_ready` equals `!out_valid || out_ready`. A message accepted on a clock edge appears with `out_valid`=1 after that edge. After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields are offered |
| in_ready | output | 1 | Block can take a message |
| in_kind | input | 1 | 0 plain sync, 1 with history |
| in_indirect | input | 1 | Branch type for the plain kind opcode |
| in_src | input | 4 | Source tag |
| in_icnt | input | ICNT_W (8) | Instruction count |
| in_addr | input | ADDR_W (32) | Full target address |
| in_hist | input | HIST_W (32) | Branch history word |
| out_valid | output | 1 | Packed message is present |
| out_ready | input | 1 | Consumer takes the message |
| out_data | output | MSG_W (82) | Packed message, zero above the length |
| out_len | output | LEN_W (7) | Message length in bits |

## Verification
The bench builds the block with the default field widths: an 8-bit count, a 32-bit address and a 32-bit history. With these widths the extremes of 12, 13, 50 and 82 bits can be reached, and a full message fills every bit of the output vector. Random field values with random significant widths place the address and history fields at many different start positions. Random consumer stalls exercise the hold and back-pressure behaviour.

// File: rtl/trace_pack_pkg.sv
package trace_pack_pkg;

    localparam int OPC_W      = 6;
    localparam int SRC_W      = 4;
    localparam int DEF_ICNT_W = 8;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_HIST_W = 32;
    localparam int FIXED_W    = OPC_W + SRC_W;

    localparam logic [OPC_W-1:0] OPC_SYNC_DIR = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_SYNC_IND = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_HIST     = 6'b011101;

    typedef enum logic {
        KIND_SYNC = 1'b0,
        KIND_HIST = 1'b1
    } msg_kind_e;

    function automatic logic [OPC_W-1:0] pick_opcode(msg_kind_e kind, logic indirect);
        if (kind == KIND_HIST) return OPC_HIST;
        return indirect ? OPC_SYNC_IND : OPC_SYNC_DIR;
    endfunction

endpackage

// File: rtl/tpk_sizer.sv
module tpk_sizer #(
    parameter int W  = 8,
    parameter int LW = 7
) (
    input  logic [W-1:0]  value,
    output logic [LW-1:0] width
);
    always_comb begin
        width = LW'(1);
        for (int i = 0; i < W; i++) begin
            if (value[i]) width = LW'(i + 1);
        end
    end
endmodule

// File: rtl/tpk_assemble.sv
module tpk_assemble
    import trace_pack_pkg::*;
#(
    parameter int ICNT_W = DEF_ICNT_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int HIST_W = DEF_HIST_W,
    parameter int MSG_W  = FIXED_W + ICNT_W + ADDR_W + HIST_W,
    parameter int LEN_W  = $clog2(MSG_W + 1)
) (
    input  msg_kind_e         kind,
    input  logic              indirect,
    input  logic [SRC_W-1:0]  src,
    input  logic [ICNT_W-1:0] icnt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HIST_W-1:0] hist,
    output logic [MSG_W-1:0]  data,
    output logic [LEN_W-1:0]  len
);
    logic [LEN_W-1:0] w_icnt, w_addr, w_hist;
    logic [LEN_W-1:0] pos_addr, pos_hist, end_addr;

    tpk_sizer #(.W(ICNT_W), .LW(LEN_W)) u_sz_icnt (.value(icnt), .width(w_icnt));
    tpk_sizer #(.W(ADDR_W), .LW(LEN_W)) u_sz_addr (.value(addr), .width(w_addr));
    tpk_sizer #(.W(HIST_W), .LW(LEN_W)) u_sz_hist (.value(hist), .width(w_hist));

    always_comb begin
        pos_addr = LEN_W'(FIXED_W) + w_icnt;
        end_addr = pos_addr + w_addr;
        pos_hist = end_addr;

        data = MSG_W'(pick_opcode(kind, indirect));
        data = data | (MSG_W'(src)  << OPC_W);
        data = data | (MSG_W'(icnt) << FIXED_W);
        data = data | (MSG_W'(addr) << pos_addr);
        if (kind == KIND_HIST) begin
            data = data | (MSG_W'(hist) << pos_hist);
            len  = pos_hist + w_hist;
        end else begin
            len  = end_addr;
        end
    end
endmodule

// File: rtl/tpk_out_stage.sv
module tpk_out_stage #(
    parameter int MSG_W = 82,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    output logic             load_ready,
    input  logic [MSG_W-1:0] load_data,
    input  logic [LEN_W-1:0] load_len,
    output logic             hold_valid,
    input  logic             take,
    output logic [MSG_W-1:0] hold_data,
    output logic [LEN_W-1:0] hold_len
);
    assign load_ready = !hold_valid || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            hold_len   <= '0;
        end else if (load_ready) begin
            hold_valid <= load_valid;
            if (load_valid) begin
                hold_data <= load_data;
                hold_len  <= load_len;
            end
        end
    end
endmodule

// File: rtl/trace_msg_packer.sv
module trace_msg_packer
    import trace_pack_pkg::*;
#(
    parameter int ICNT_W = DEF_ICNT_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int HIST_W = DEF_HIST_W,
    parameter int MSG_W  = FIXED_W + ICNT_W + ADDR_W + HIST_W,
    parameter int LEN_W  = $clog2(MSG_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_kind,
    input  logic              in_indirect,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [ICNT_W-1:0] in_icnt,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [HIST_W-1:0] in_hist,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [MSG_W-1:0]  out_data,
    output logic [LEN_W-1:0]  out_len
);
    logic [MSG_W-1:0] asm_data;
    logic [LEN_W-1:0] asm_len;
    msg_kind_e        kind;

    assign kind = msg_kind_e'(in_kind);

    tpk_assemble #(
        .ICNT_W(ICNT_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W),
        .MSG_W(MSG_W), .LEN_W(LEN_W)
    ) u_asm (
        .kind(kind), .indirect(in_indirect), .src(in_src),
        .icnt(in_icnt), .addr(in_addr), .hist(in_hist),
        .data(asm_data), .len(asm_len)
    );

    tpk_out_stage #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_out (
        .clk(clk), .rst(rst),
        .load_valid(in_valid), .load_ready(in_ready),
        .load_data(asm_data), .load_len(asm_len),
        .hold_valid(out_valid), .take(out_ready),
        .hold_data(out_data), .hold_len(out_len)
    );
endmodule

// File: rtl/tpk_checker.sv
module tpk_checker #(
    parameter int MSG_W = 82,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [MSG_W-1:0] out_data,
    input logic [LEN_W-1:0] out_len
);
    assert_opcode_legal_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[5:0] == 6'b001011 || out_data[5:0] == 6'b001100
                       || out_data[5:0] == 6'b011101));

    assert_len_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len >= LEN_W'(12) && out_len <= LEN_W'(MSG_W)));

    assert_hist_min_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[5:0] == 6'b011101) |-> out_len >= LEN_W'(13));

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data >> out_len) == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_len)));

    assert_backpressure_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind trace_msg_packer tpk_checker #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_len(out_len)
);

// File: tb/trace_msg_packer_tb.sv
module trace_msg_packer_tb;
    localparam int MSG_W = 82;
    localparam int LEN_W = 7;
    localparam int NMSG  = 400;
    localparam int NDIR  = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_kind = 1'b0;
    logic             in_indirect = 1'b0;
    logic [3:0]       in_src = '0;
    logic [7:0]       in_icnt = '0;
    logic [31:0]      in_addr = '0;
    logic [31:0]      in_hist = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [MSG_W-1:0] out_data;
    logic [LEN_W-1:0] out_len;

    int nchk = 0;
    int nerr = 0;
    int idx  = 0;
    logic [MSG_W-1:0] exp_d[$];
    int               exp_l[$];
    logic             in_took = 1'b0;
    logic             pushed_last = 1'b0;
    logic             held = 1'b0;
    logic [MSG_W-1:0] held_d;
    logic [LEN_W-1:0] held_l;
    int unsigned      seed_v;

    always #5 clk = ~clk;

    trace_msg_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_indirect(in_indirect), .in_src(in_src),
        .in_icnt(in_icnt), .in_addr(in_addr), .in_hist(in_hist),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_len(out_len)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sigw(logic [31:0] v);
        int n = 1;
        for (int i = 0; i < 32; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    function automatic logic [MSG_W-1:0] ref_data(logic k, logic ind, logic [3:0] s,
            logic [7:0] c, logic [31:0] a, logic [31:0] h, output int len);
        logic [MSG_W-1:0] d;
        int pos;
        d = k ? MSG_W'(6'b011101) : (ind ? MSG_W'(6'b001100) : MSG_W'(6'b001011));
        d = d | (MSG_W'(s) << 6);
        d = d | (MSG_W'(c) << 10);
        pos = 10 + sigw({24'd0, c});
        d = d | (MSG_W'(a) << pos);
        pos = pos + sigw(a);
        if (k) begin
            d = d | (MSG_W'(h) << pos);
            pos = pos + sigw(h);
        end
        len = pos;
        return d;
    endfunction

    function automatic logic [31:0] rnd_val(int maxw);
        int w = $urandom_range(0, maxw);
        logic [63:0] m = (64'd1 << w) - 64'd1;
        return $urandom & m[31:0];
    endfunction

    task automatic gen_stim(int n);
        case (n)
            0: begin in_kind = 0; in_indirect = 0; in_src = 4'h0; in_icnt = 8'h00; in_addr = 32'h0; in_hist = 32'h0; end
            1: begin in_kind = 0; in_indirect = 1; in_src = 4'hF; in_icnt = 8'hFF; in_addr = 32'hFFFF_FFFF; in_hist = 32'h0; end
            2: begin in_kind = 1; in_indirect = 0; in_src = 4'h0; in_icnt = 8'h00; in_addr = 32'h0; in_hist = 32'h0; end
            3: begin in_kind = 1; in_indirect = 1; in_src = 4'hF; in_icnt = 8'hFF; in_addr = 32'hFFFF_FFFF; in_hist = 32'hFFFF_FFFF; end
            4: begin in_kind = 0; in_indirect = 0; in_src = 4'h5; in_icnt = 8'h01; in_addr = 32'h2; in_hist = 32'hFFFF_FFFF; end
            5: begin in_kind = 1; in_indirect = 0; in_src = 4'hA; in_icnt = 8'h80; in_addr = 32'h1; in_hist = 32'h8000_0000; end
            6: begin in_kind = 0; in_indirect = 1; in_src = 4'h3; in_icnt = 8'h10; in_addr = 32'h100; in_hist = 32'h1234; end
            default: begin
                in_kind = 1'($urandom);
                in_indirect = 1'($urandom);
                in_src = 4'($urandom);
                in_icnt = rnd_val(8)[7:0];
                in_addr = rnd_val(32);
                in_hist = rnd_val(32);
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int ln;
        logic [MSG_W-1:0] dd;
        seed_v = $urandom(32'd7715);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 reset out_valid", 128'(out_valid), 128'(0));
        chk("R9 reset in_ready", 128'(in_ready), 128'(1));

        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (pushed_last) chk("R9 latency out_valid", 128'(out_valid), 128'(1));
            if (held) begin
                chk("R8 hold valid", 128'(out_valid), 128'(1));
                chk("R8 hold data", 128'(out_data), 128'(held_d));
                chk("R8 hold len", 128'(out_len), 128'(held_l));
            end
            if (!in_valid || in_took) begin
                if (idx < NMSG) begin
                    in_valid = (idx < NDIR) ? 1'b1 : ($urandom % 4 != 0);
                    if (in_valid) begin
                        gen_stim(idx);
                        idx++;
                    end
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = (cyc < 20) ? 1'b1 : ($urandom % 3 != 0);
            #1;
            chk("R9 ready rule", 128'(in_ready), 128'(!out_valid || out_ready));
            in_took = in_valid && in_ready;
            if (in_took) begin
                dd = ref_data(in_kind, in_indirect, in_src, in_icnt, in_addr, in_hist, ln);
                exp_d.push_back(dd);
                exp_l.push_back(ln);
            end
            pushed_last = in_took;
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0) begin
                    chk("R9 unexpected output", 128'(1), 128'(0));
                end else begin
                    dd = exp_d.pop_front();
                    ln = exp_l.pop_front();
                    chk("R1 opcode", 128'(out_data[5:0]), 128'(dd[5:0]));
                    chk("R2 source", 128'(out_data[9:6]), 128'(dd[9:6]));
                    chk("R3 R4 R5 packed data", 128'(out_data), 128'(dd));
                    chk("R6 length", 128'(out_len), 128'(ln));
                    chk("R7 zero padding", 128'(out_data >> out_len), 128'(0));
                end
            end
            held = out_valid && !out_ready;
            held_d = out_data;
            held_l = out_len;
        end
        chk("R9 all messages delivered", 128'(exp_d.size()), 128'(0));
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule